// File: doc/BRIEF.md
# Page-Buffered Write Cycle Controller

This block sits behind a serial-bus slave in a small non-volatile memory. The slave passes it a starting word address, then complete data bytes, then a STOP event. The block collects the bytes in a one-page buffer. On an accepted STOP it commits the loaded buffer slots to the memory array, one slot per clock, in slot order. After that it holds a busy state for a fixed write time, given in system clocks. While busy, it accepts no further command.

The data address increments only within a 16-byte page. A transfer that runs past the end of the page wraps back to the start of the same page. More than a page of data overwrites earlier slots. A write-protect input can cancel the write, but only from the moment the first data byte's last bit is sampled. Before that point the input is ignored. Raised during the busy time, write protect ends the cycle at once: slots not yet committed keep their old contents, and a sticky flag marks the page contents as unreliable. A low-supply input blocks every array write.

Top module: `page_write_ctrl`

## Requirements
- R1: Data bytes go to consecutive addresses starting at the loaded word address. Only the low 4 address bits advance, wrapping from 0xF to 0x0, and the upper bits stay fixed.
- R2: When more than 16 bytes are sent, each later byte replaces the byte in the same slot. The committed value of each slot is the last byte written to it.
- R3: A STOP with no data byte since the last address load starts no busy state and no array write.
- R4: After an accepted STOP, busy_o is high from the next cycle for exactly TWR_CYC cycles. In busy cycle k (k = 0..15), slot k is written to {page, k} if it was loaded. No other ram_we_o pulse occurs.
- R5: While busy_o is high, address loads, data strobes, first-bit strobes and STOP events are ignored.
- R6: A high write-protect level before the first-bit strobe of the first data byte has no effect on the write.
- R7: Write protect high at or after the first-bit strobe and before STOP cancels the pending write. The STOP then starts no busy state and no array write.
- R8: Write protect high in a busy cycle suppresses ram_we_o in that cycle and drops busy_o on the next cycle. Slots not yet committed keep their old contents. data_bad_o is then set and stays set until the next address load.
- R9: Low supply high at STOP discards the write. Low supply high during the busy time suppresses ram_we_o in those cycles, without shortening the busy time.
- R10: After reset, busy_o, ram_we_o and data_bad_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wa_load_i | input | 1 | Word address strobe; starts a new write transaction |
| wa_i | input | AW | Starting word address |
| wd_strobe_i | input | 1 | A complete data byte is available |
| wd_i | input | 8 | Data byte |
| d0_seen_i | input | 1 | Last bit of the first data byte has been sampled |
| stop_i | input | 1 | STOP event from the bus |
| wp_i | input | 1 | Write-protect level |
| lowv_i | input | 1 | Low-supply indication |
| busy_o | output | 1 | Internal write in progress |
| ram_we_o | output | 1 | Array write enable |
| ram_addr_o | output | AW | Array write address |
| ram_wdata_o | output | 8 | Array write data |
| data_bad_o | output | 1 | Sticky flag: a write was ended by force |

## Verification
A wrong slot pointer shows up in the address of a ram_we_o pulse during the first 16 busy cycles. The array contents checked after the cycle reveal it as well. A wrong timer or state register shows up as busy_o rising or falling one cycle off, which the per-cycle comparison catches in that same cycle. A wrongly latched cancel or arm bit shows up either as a busy state after a STOP that should have been refused, or as a missing one after a STOP that should have been accepted. A forced-end fault shows up as a write pulse in the abort cycle, or as busy_o still high one cycle later.

// File: rtl/page_write_ctrl.sv
`timescale 1ns/1ps
module page_write_ctrl #(
  parameter int AW      = 10,
  parameter int PW      = 4,
  parameter int TWR_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wa_load_i,
  input  logic [AW-1:0] wa_i,
  input  logic          wd_strobe_i,
  input  logic [7:0]    wd_i,
  input  logic          d0_seen_i,
  input  logic          stop_i,
  input  logic          wp_i,
  input  logic          lowv_i,
  output logic          busy_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  output logic          data_bad_o
);
  localparam int PD = 1 << PW;
  localparam int TW = $clog2(TWR_CYC) + 1;

  logic [AW-PW-1:0] page_q;
  logic [PW-1:0]    ptr_q;
  logic [7:0]       pg_q [PD];
  logic [PD-1:0]    vld_q;
  logic             armed_q, cancel_q, any_q, busy_q, bad_q;
  logic [TW-1:0]    tmr_q;

  logic [PW-1:0] slot;
  logic          committing, accept, last;

  assign slot        = tmr_q[PW-1:0];
  assign committing  = busy_q && (tmr_q < TW'(PD));
  assign last        = (tmr_q == TW'(TWR_CYC - 1));
  assign accept      = !busy_q && stop_i && any_q && !cancel_q
                       && !(armed_q && wp_i) && !lowv_i;

  assign busy_o      = busy_q;
  assign data_bad_o  = bad_q;
  assign ram_we_o    = committing && vld_q[slot] && !wp_i && !lowv_i;
  assign ram_addr_o  = {page_q, slot};
  assign ram_wdata_o = pg_q[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      ptr_q    <= '0;
      vld_q    <= '0;
      armed_q  <= 1'b0;
      cancel_q <= 1'b0;
      any_q    <= 1'b0;
      busy_q   <= 1'b0;
      bad_q    <= 1'b0;
      tmr_q    <= '0;
    end else if (busy_q) begin
      if (wp_i) begin
        busy_q <= 1'b0;
        bad_q  <= 1'b1;
        vld_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
        vld_q  <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end else if (wa_load_i) begin
      page_q   <= wa_i[AW-1:PW];
      ptr_q    <= wa_i[PW-1:0];
      vld_q    <= '0;
      armed_q  <= 1'b0;
      cancel_q <= 1'b0;
      any_q    <= 1'b0;
      bad_q    <= 1'b0;
    end else if (stop_i) begin
      armed_q  <= 1'b0;
      cancel_q <= 1'b0;
      any_q    <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        tmr_q  <= '0;
      end else begin
        vld_q <= '0;
      end
    end else begin
      if (d0_seen_i) armed_q <= 1'b1;
      if ((armed_q || d0_seen_i) && wp_i) cancel_q <= 1'b1;
      if (wd_strobe_i) begin
        vld_q[ptr_q] <= 1'b1;
        ptr_q        <= ptr_q + 1'b1;
        any_q        <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!busy_q && !wa_load_i && !stop_i && wd_strobe_i)
      pg_q[ptr_q] <= wd_i;
  end

  a_r4_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> busy_o);
  a_r8_no_we_under_wp: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> !ram_we_o);
  a_r8_abort_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && wp_i) |=> (!busy_o && data_bad_o));
  a_r8_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (data_bad_o && !wa_load_i) |=> data_bad_o);
  a_r9_no_we_lowv: assert property (@(posedge clk) disable iff (!rst_n)
    lowv_i |-> !ram_we_o);
  a_r3_no_start_without_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !stop_i) |=> !busy_o);
  a_r5_addr_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(ram_addr_o[AW-1:PW]));
endmodule

// File: tb/page_write_ctrl_test.sv
`timescale 1ns/1ps
module page_write_ctrl_test;
  localparam int TWR = 40;
  logic clk = 0, rst_n = 0;
  logic wa_load = 0, wd_stb = 0, d0 = 0, stop = 0, wp = 0, lowv = 0;
  logic [9:0] wa = 0;
  logic [7:0] wd = 0;
  logic busy, we, bad;
  logic [9:0] addr;
  logic [7:0] wdata;

  page_write_ctrl #(.AW(10), .PW(4), .TWR_CYC(TWR)) uut (
    .clk(clk), .rst_n(rst_n), .wa_load_i(wa_load), .wa_i(wa),
    .wd_strobe_i(wd_stb), .wd_i(wd), .d0_seen_i(d0), .stop_i(stop),
    .wp_i(wp), .lowv_i(lowv), .busy_o(busy), .ram_we_o(we),
    .ram_addr_o(addr), .ram_wdata_o(wdata), .data_bad_o(bad));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] exp_mem [0:1023];

  int m_busy = 0, m_tmr = 0, m_bad = 0, m_arm = 0, m_can = 0, m_any = 0;
  int m_page = 0, m_ptr = 0;
  int m_vld [16];
  int m_buf [16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (rst_n) begin
      if (m_busy != 0) begin
        if (wp) begin
          m_busy = 0; m_bad = 1;
          foreach (m_vld[i]) m_vld[i] = 0;
        end else begin
          if (m_tmr < 16 && m_vld[m_tmr] != 0 && !lowv)
            exp_mem[m_page * 16 + m_tmr] = m_buf[m_tmr][7:0];
          if (m_tmr == TWR - 1) begin
            m_busy = 0;
            foreach (m_vld[i]) m_vld[i] = 0;
          end else m_tmr++;
        end
      end else if (wa_load) begin
        m_page = int'(wa) / 16; m_ptr = int'(wa) % 16;
        foreach (m_vld[i]) m_vld[i] = 0;
        m_arm = 0; m_can = 0; m_any = 0; m_bad = 0;
      end else if (stop) begin
        if (m_any != 0 && m_can == 0 && !(m_arm != 0 && wp) && !lowv) begin
          m_busy = 1; m_tmr = 0;
        end else foreach (m_vld[i]) m_vld[i] = 0;
        m_arm = 0; m_can = 0; m_any = 0;
      end else begin
        if (d0) m_arm = 1;
        if (m_arm != 0 && wp) m_can = 1;
        if (wd_stb) begin
          m_buf[m_ptr] = int'(wd); m_vld[m_ptr] = 1;
          m_ptr = (m_ptr + 1) % 16; m_any = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit ew;
      ew = m_busy != 0 && m_tmr < 16 && m_vld[m_tmr % 16] != 0 && !wp && !lowv;
      chk(busy == (m_busy != 0), "R4 busy", busy, m_busy);
      chk(we == ew, "R4 write enable", we, ew);
      chk(bad == (m_bad != 0), "R8 flag", bad, m_bad);
      if (ew) chk(addr == 10'(m_page * 16 + m_tmr) && wdata == m_buf[m_tmr][7:0],
                  "R1 commit addr/data", {addr, wdata}, (m_page * 16 + m_tmr) * 256 + m_buf[m_tmr]);
    end
  end

  task automatic load(input int a);
    @(negedge clk) wa = 10'(a); wa_load = 1;
    @(negedge clk) wa_load = 0;
  endtask
  task automatic first_bit();
    @(negedge clk) d0 = 1;
    @(negedge clk) d0 = 0;
  endtask
  task automatic send(input int v);
    @(negedge clk) wd = 8'(v); wd_stb = 1;
    @(negedge clk) wd_stb = 0;
  endtask
  task automatic send_stop();
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
  endtask
  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    @(negedge clk);
  endtask

  int cyc;
  bit done = 0;

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
    foreach (m_vld[i]) begin m_vld[i] = 0; m_buf[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0 && we == 0 && bad == 0, "R10 reset", {busy, we, bad}, 0);
    rst_n = 1;

    load(12'h10E); first_bit(); send(8'h11); send(8'h22); send(8'h33);
    send_stop();
    chk(busy == 1, "R4 busy after stop", busy, 1);
    wait_idle(cyc);
    chk(cyc == TWR, "R4 busy length", cyc, TWR);
    chk(mem[10'h10E] == 8'h11, "R1 first", mem[10'h10E], 8'h11);
    chk(mem[10'h10F] == 8'h22, "R1 second", mem[10'h10F], 8'h22);
    chk(mem[10'h100] == 8'h33, "R1 wrap", mem[10'h100], 8'h33);
    chk(mem[10'h110] == 8'hFF, "R1 next page untouched", mem[10'h110], 8'hFF);

    load(12'h020); first_bit();
    for (int i = 0; i < 18; i++) send(8'h40 + i);
    send_stop(); wait_idle(cyc);
    chk(mem[10'h020] == 8'h50, "R2 slot0", mem[10'h020], 8'h50);
    chk(mem[10'h021] == 8'h51, "R2 slot1", mem[10'h021], 8'h51);
    chk(mem[10'h022] == 8'h42, "R2 slot2", mem[10'h022], 8'h42);
    chk(mem[10'h02F] == 8'h4F, "R2 slot15", mem[10'h02F], 8'h4F);

    load(12'h030); send_stop();
    chk(busy == 0, "R3 empty stop", busy, 0);

    load(12'h050); first_bit(); send(8'h5A); send_stop();
    load(12'h060); first_bit(); send(8'h66); send_stop();
    wait_idle(cyc);
    chk(mem[10'h050] == 8'h5A, "R5 first write", mem[10'h050], 8'h5A);
    chk(mem[10'h060] == 8'hFF, "R5 ignored while busy", mem[10'h060], 8'hFF);
    repeat (2) @(negedge clk);
    chk(busy == 0, "R5 no second cycle", busy, 0);

    @(negedge clk) wp = 1;
    load(12'h070);
    @(negedge clk) wp = 0;
    first_bit(); send(8'h77); send_stop(); wait_idle(cyc);
    chk(mem[10'h070] == 8'h77, "R6 early protect ignored", mem[10'h070], 8'h77);

    load(12'h080); first_bit(); send(8'h88);
    @(negedge clk) wp = 1;
    @(negedge clk) wp = 0;
    send_stop();
    chk(busy == 0, "R7 cancelled no busy", busy, 0);
    repeat (20) @(negedge clk);
    chk(mem[10'h080] == 8'hFF, "R7 cancelled no write", mem[10'h080], 8'hFF);

    load(12'h090); first_bit();
    for (int i = 0; i < 16; i++) send(8'hA0 + i);
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    repeat (5) @(negedge clk);
    wp = 1;
    @(negedge clk) wp = 0;
    #1;
    chk(busy == 0, "R8 abort drops busy", busy, 0);
    chk(bad == 1, "R8 flag set", bad, 1);
    chk(mem[10'h094] == 8'hA4, "R8 committed slot", mem[10'h094], 8'hA4);
    chk(mem[10'h095] == 8'hFF, "R8 abort slot", mem[10'h095], 8'hFF);
    chk(mem[10'h09F] == 8'hFF, "R8 later slot", mem[10'h09F], 8'hFF);
    repeat (4) @(negedge clk);
    #1;
    chk(bad == 1, "R8 flag sticky", bad, 1);
    load(12'h0B0);
    #1;
    chk(bad == 0, "R8 flag cleared by load", bad, 0);

    first_bit(); send(8'hB1);
    @(negedge clk) lowv = 1; stop = 1;
    @(negedge clk) lowv = 0; stop = 0;
    chk(busy == 0, "R9 low supply at stop", busy, 0);

    load(12'h0C0); first_bit(); send(8'hC0); send(8'hC1); send(8'hC2);
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0; lowv = 1;
    @(negedge clk);
    @(negedge clk) lowv = 0;
    wait_idle(cyc);
    chk(cyc == TWR - 2, "R9 busy not shortened", cyc, TWR - 2);
    chk(mem[10'h0C0] == 8'hFF, "R9 suppressed slot0", mem[10'h0C0], 8'hFF);
    chk(mem[10'h0C1] == 8'hFF, "R9 suppressed slot1", mem[10'h0C1], 8'hFF);
    chk(mem[10'h0C2] == 8'hC2, "R9 slot2 written", mem[10'h0C2], 8'hC2);

    for (int i = 0; i < 1024; i++)
      if (mem[i] != exp_mem[i]) chk(0, "R4 array image", mem[i], exp_mem[i]);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        chk(0, "R4 watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule